// File: doc/BRIEF.md
# Reset Pinstrap Boot-ROM Configuration

This block fixes the boot ROM setup before any firmware runs. While reset is held it samples four strap inputs on every clock edge, and it keeps the last sampled values once reset is released. The straps set three things: the data width of the boot ROM chip-select, the enable for the external data-bus buffer controls, and whether the boot ROM decode reaches its own chip-select pin or is rerouted to the chip selects of PC Card socket A. After reset, a one-cycle write port lets firmware set a new width and a new steering choice.

On each ROM access the block produces the routed chip-select. When the active width is 32 bits it also asserts the output enable of the 32-bit ROM buffer. The block never combines steering to the socket with a 32-bit width. When such a request arrives, the decode stays on the ROM pin and a sticky error flag is set. The reserved width code is handled as 8-bit and also sets the flag. A status word always presents the captured straps, the active width, the steering state and the error flag.

Top module: `romstrap_top`

## Requirements
- R1: While rstN is low the block captures strapIn on every rising clock edge. After release it applies the captured values: bits [1:0] give the width code, bit 2 requests socket steering and bit 3 is the buffer enable.
- R2: Changes on strapIn after rstN goes high change neither cfgStatus nor any other output.
- R3: Width code 2'b00 is x8, 2'b10 is x16 and 2'b11 is x32. romWidth reports the active code.
- R4: The reserved width code 2'b01, whether from the straps or from a write, becomes active as 2'b00 (x8) and sets the error flag.
- R5: rom32BufOe equals romAccess when the active width is 2'b11 and is 0 for any other width.
- R6: bufCtrlEn equals captured strap bit 3, whatever the width.
- R7: When steering is off, romCsPin follows romAccess and socketCs is 0. When steering is on, socketCs follows romAccess and romCsPin is 0.
- R8: A request to steer while the resulting width is x32, from the straps or from a write, leaves steering off and sets the error flag.
- R9: A write (wrEn high) loads wrWidth and wrSteer on the next rising edge. An access in the same cycle as the write still uses the old setting.
- R10: The error flag stays set until the next reset. During reset it is recomputed from the straps.
- R11: cfgStatus packs the following fields: [3:0] captured straps, [5:4] active width code, [6] steering, [7] error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; straps are sampled while it is low |
| strapIn | input | 4 | Configuration strap inputs |
| wrEn | input | 1 | Firmware write strobe |
| wrWidth | input | 2 | Width code to write |
| wrSteer | input | 1 | Socket steering request to write |
| romAccess | input | 1 | Boot ROM chip-select decode hit for the current access |
| romCsPin | output | 1 | Routed ROM chip-select pin |
| socketCs | output | 1 | Routed socket A chip select |
| rom32BufOe | output | 1 | Output enable of the 32-bit ROM buffer |
| bufCtrlEn | output | 1 | Enable for the data-bus buffer controls |
| romWidth | output | 2 | Active width code |
| cfgStatus | output | 8 | Status word |

## Verification
A firmware write and a ROM access can occur in the same cycle. The bench raises wrEn and romAccess together, with the write flipping steering from pin to socket. Within that cycle it expects romCsPin still high and socketCs still low. After the next edge it expects the access to appear on socketCs. A second case writes x32 together with steering and expects steering to stay off and the error flag to rise.

// File: rtl/romstrap_pkg.sv
package romstrap_pkg;

  localparam logic [1:0] WCODE_X8  = 2'b00;
  localparam logic [1:0] WCODE_RSV = 2'b01;
  localparam logic [1:0] WCODE_X16 = 2'b10;
  localparam logic [1:0] WCODE_X32 = 2'b11;

  localparam int STRAP_WLO   = 0;
  localparam int STRAP_STEER = 2;
  localparam int STRAP_BUF   = 3;

  typedef struct packed {
    logic       loadStrap;
    logic       loadCfg;
    logic       errClr;
    logic       errSet;
    logic [1:0] widthNext;
    logic       steerNext;
  } cfgStrobe_t;

endpackage

// File: rtl/romstrap_ctrl.sv
module romstrap_ctrl
  import romstrap_pkg::*;
#(
  parameter int STRAP_W = 4
) (
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               wrEn,
  input  logic [1:0]         wrWidth,
  input  logic               wrSteer,
  output cfgStrobe_t         strobe
);

  logic [1:0] reqWidth;
  logic       reqSteer;
  logic [1:0] effWidth;
  logic       isRsv;
  logic       isClash;
  logic       doLoad;

  always_comb begin
    if (!rstN) begin
      reqWidth = strapIn[STRAP_WLO+1:STRAP_WLO];
      reqSteer = strapIn[STRAP_STEER];
    end else begin
      reqWidth = wrWidth;
      reqSteer = wrSteer;
    end
    isRsv    = (reqWidth == WCODE_RSV);
    effWidth = isRsv ? WCODE_X8 : reqWidth;
    isClash  = reqSteer && (effWidth == WCODE_X32);
    doLoad   = !rstN || wrEn;

    strobe.loadStrap = !rstN;
    strobe.loadCfg   = doLoad;
    strobe.errClr    = !rstN;
    strobe.errSet    = doLoad && (isRsv || isClash);
    strobe.widthNext = effWidth;
    strobe.steerNext = reqSteer && !isClash;
  end

endmodule

// File: rtl/romstrap_dp.sv
module romstrap_dp
  import romstrap_pkg::*;
#(
  parameter int STRAP_W = 4,
  localparam int STAT_W = STRAP_W + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               romAccess,
  output logic               romCsPin,
  output logic               socketCs,
  output logic               rom32BufOe,
  output logic               bufCtrlEn,
  output logic [1:0]         romWidth,
  output logic [STAT_W-1:0]  cfgStatus
);

  logic [STRAP_W-1:0] strapQ;
  logic [1:0]         widthQ;
  logic               steerQ;
  logic               errQ;

  always_ff @(posedge clk) begin
    if (strobe.loadStrap) strapQ <= strapIn;
    if (strobe.loadCfg) begin
      widthQ <= strobe.widthNext;
      steerQ <= strobe.steerNext;
    end
    errQ <= (strobe.errClr ? 1'b0 : errQ) | strobe.errSet;
  end

  assign romCsPin   = romAccess && !steerQ;
  assign socketCs   = romAccess && steerQ;
  assign rom32BufOe = romAccess && (widthQ == WCODE_X32);
  assign bufCtrlEn  = strapQ[STRAP_BUF];
  assign romWidth   = widthQ;
  assign cfgStatus  = {errQ, steerQ, widthQ, strapQ};

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapQ)); // R2
  AST_NO_RSV_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    widthQ != WCODE_RSV); // R4
  AST_NO_STEER_X32: assert property (@(posedge clk) disable iff (!rstN)
    !(steerQ && widthQ == WCODE_X32)); // R8
  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(romCsPin && socketCs)); // R7
  AST_BUF32_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    rom32BufOe |-> romAccess); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(errQ) |-> errQ); // R10
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCfg && strobe.steerNext |=> steerQ); // R9

endmodule

// File: rtl/romstrap_top.sv
module romstrap_top
  import romstrap_pkg::*;
#(
  parameter int STRAP_W = 4,
  localparam int STAT_W = STRAP_W + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               wrEn,
  input  logic [1:0]         wrWidth,
  input  logic               wrSteer,
  input  logic               romAccess,
  output logic               romCsPin,
  output logic               socketCs,
  output logic               rom32BufOe,
  output logic               bufCtrlEn,
  output logic [1:0]         romWidth,
  output logic [STAT_W-1:0]  cfgStatus
);

  cfgStrobe_t strobe;

  romstrap_ctrl #(.STRAP_W(STRAP_W)) ctrl_i (
    .rstN    (rstN),
    .strapIn (strapIn),
    .wrEn    (wrEn),
    .wrWidth (wrWidth),
    .wrSteer (wrSteer),
    .strobe  (strobe)
  );

  romstrap_dp #(.STRAP_W(STRAP_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .strapIn    (strapIn),
    .romAccess  (romAccess),
    .romCsPin   (romCsPin),
    .socketCs   (socketCs),
    .rom32BufOe (rom32BufOe),
    .bufCtrlEn  (bufCtrlEn),
    .romWidth   (romWidth),
    .cfgStatus  (cfgStatus)
  );

endmodule

// File: tb/romstrap_top_tb_top.sv
module romstrap_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] strapIn;
  logic       wrEn;
  logic [1:0] wrWidth;
  logic       wrSteer;
  logic       romAccess;
  logic       romCsPin, socketCs, rom32BufOe, bufCtrlEn;
  logic [1:0] romWidth;
  logic [7:0] cfgStatus;

  int vecs = 0;
  int miss = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  romstrap_top dut_i (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .wrEn(wrEn), .wrWidth(wrWidth),
    .wrSteer(wrSteer), .romAccess(romAccess), .romCsPin(romCsPin),
    .socketCs(socketCs), .rom32BufOe(rom32BufOe), .bufCtrlEn(bufCtrlEn),
    .romWidth(romWidth), .cfgStatus(cfgStatus)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStat(input logic [3:0] s);
    logic [1:0] w;
    logic st, er;
    w  = (s[1:0] == 2'b01) ? 2'b00 : s[1:0];
    er = (s[1:0] == 2'b01) || (s[2] && w == 2'b11);
    st = s[2] && (w != 2'b11);
    return {er, st, w, s};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic [3:0] s);
    @(negedge clk);
    rstN = 1'b0; strapIn = s; wrEn = 1'b0; romAccess = 1'b0;
    tick(); tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic chkAccess(input string req, input logic ePin, input logic eSock, input logic eBuf);
    romAccess = 1'b1;
    #1;
    chk(req, {5'b0, romCsPin, socketCs, rom32BufOe}, {5'b0, ePin, eSock, eBuf});
    romAccess = 1'b0;
    #1;
    chk(req, {5'b0, romCsPin, socketCs, rom32BufOe}, 8'h00);
  endtask

  task automatic testDefaults();
    doReset(4'b0000);
    chk("R1 R11 status", cfgStatus, 8'h00);
    chk("R3 width x8", {6'b0, romWidth}, 8'h00);
    chk("R6 buf off", {7'b0, bufCtrlEn}, 8'h00);
    chkAccess("R7 pin route", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testX32Buf();
    doReset(4'b1011);
    chk("R1 R11 status x32", cfgStatus, expStat(4'b1011));
    chk("R3 width x32", {6'b0, romWidth}, 8'h03);
    chk("R6 buf on", {7'b0, bufCtrlEn}, 8'h01);
    chkAccess("R5 buf32 on x32", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testX16();
    doReset(4'b1010);
    chk("R3 status x16", cfgStatus, expStat(4'b1010));
    chk("R6 buf on x16", {7'b0, bufCtrlEn}, 8'h01);
    chkAccess("R5 buf32 off x16", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testSteerStrap();
    doReset(4'b0100);
    chk("R7 status steer", cfgStatus, expStat(4'b0100));
    chkAccess("R7 socket route", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testClashStrap();
    doReset(4'b0111);
    chk("R8 strap clash", cfgStatus, 8'hB7);
    chkAccess("R8 stays pin", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testRsvStrap();
    doReset(4'b0001);
    chk("R4 strap reserved", cfgStatus, 8'h81);
    chkAccess("R4 acts x8", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testStrapIgnored();
    doReset(4'b0010);
    strapIn = 4'b1111;
    tick(); tick();
    chk("R2 straps ignored", cfgStatus, expStat(4'b0010));
    chk("R2 buf ignored", {7'b0, bufCtrlEn}, 8'h00);
    chkAccess("R2 route ignored", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testWriteSameCycle();
    doReset(4'b0000);
    wrEn = 1'b1; wrWidth = 2'b10; wrSteer = 1'b1; romAccess = 1'b1;
    #1;
    chk("R9 same-cycle old route", {6'b0, romCsPin, socketCs}, 8'h02);
    tick();
    wrEn = 1'b0;
    #1;
    chk("R9 new route", {6'b0, romCsPin, socketCs}, 8'h01);
    chk("R9 status after write", cfgStatus, 8'h60);
    romAccess = 1'b0;
  endtask

  task automatic testWriteClash();
    doReset(4'b0000);
    wrEn = 1'b1; wrWidth = 2'b11; wrSteer = 1'b1;
    tick();
    wrEn = 1'b0;
    chk("R8 write clash", cfgStatus, 8'hB0);
    chkAccess("R8 write clash pin", 1'b1, 1'b0, 1'b1);
    wrEn = 1'b1; wrWidth = 2'b00; wrSteer = 1'b0;
    tick();
    wrEn = 1'b0;
    chk("R10 error sticky", cfgStatus, 8'h80);
    doReset(4'b0000);
    chk("R10 reset clears", cfgStatus, 8'h00);
  endtask

  task automatic testWriteRsv();
    doReset(4'b0010);
    wrEn = 1'b1; wrWidth = 2'b01; wrSteer = 1'b1;
    tick();
    wrEn = 1'b0;
    chk("R4 write reserved", cfgStatus, 8'hC2);
    chkAccess("R4 write rsv socket", 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; strapIn = 4'b0; wrEn = 1'b0; wrWidth = 2'b0; wrSteer = 1'b0; romAccess = 1'b0;
    testDefaults();
    testX32Buf();
    testX16();
    testSteerStrap();
    testClashStrap();
    testRsvStrap();
    testStrapIgnored();
    testWriteSameCycle();
    testWriteClash();
    testWriteRsv();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule